// File: doc/BRIEF.md
# Strobe-framed serial command and display RAM front end

This block is the host-facing half of a small multiplexed LCD driver. A host sends bytes over three wires: an active-low strobe that frames a transfer, a serial clock and a data line. The block brings the three wires into the system clock domain and assembles bytes most significant bit first. Within each strobe window, the first complete byte is decoded as a command. It updates one of three flag groups or loads the RAM write address. Every later byte in the same window is stored in a 30-byte display RAM.

After each stored byte the write address either advances or holds. When it advances past the last group address of the selected duty mode, it returns to zero. The display scan reads the RAM through an asynchronous read port. The scan and output latch logic also see every flag and a one-cycle pulse on each strobe edge.

Top module: `lcd_ser_if`

## Requirements
- R1: After reset every flag output is 0, the duty code is 00 (1/2 duty), the frame divider is 00 and the write address is 0.
- R2: While the strobe is low, bits are sampled on each rising serial clock edge, most significant bit first. Serial clock edges while the strobe is high shift nothing and write nothing.
- R3: Only the first complete byte after a strobe fall is a command. Bits [7:6] select the class: 00 display mode, 01 data setting, 10 status. Bits [7:5] = 110 select address set, and 111 is ignored.
- R4: A display-mode command copies bits [1:0] to duty_o (00 or 01 = 1/2 duty, 10 = 1/3 duty, 11 = 1/4 duty) and bits [3:2] to frame_div_o.
- R5: A data-setting command copies bit 3 to latch_mode_o, bit 2 to addr_hold_o and bits [1:0] to wr_mode_o. If bit 1 is set, the whole command is ignored and all three outputs keep their values.
- R6: A status command copies bits [5:4] to test_mode_o, bit 3 to int_bias_o, bit 2 to addr_rst_o, bit 1 to latch_flag_o and bit 0 to disp_on_o.
- R7: An address-set command loads bits [4:0] into the write address.
- R8: Each non-command byte is written to the RAM at the current write address. When addr_hold_o is 0 the address then advances by one; when it is 1 the address stays put.
- R9: An advance from the last group address (14 for duty 0x, 19 for duty 10, 29 for duty 11) gives address 0.
- R10: With addr_rst_o set, a strobe rise clears the write address if the window held at least one data byte. Otherwise the address is unchanged.
- R11: Bits of an incomplete byte are dropped when the strobe rises. The next window starts with a fresh command.
- R12: Each strobe rise and each strobe fall gives exactly one single-cycle pulse on stb_rise_o or stb_fall_o, after the two-stage synchronizer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| stb_i | input | 1 | Serial strobe, active low |
| sclk_i | input | 1 | Serial shift clock |
| sdata_i | input | 1 | Serial data |
| rd_addr_i | input | 5 | Display scan RAM read address |
| rd_data_o | output | 8 | RAM byte at rd_addr_i, 0 beyond depth |
| duty_o | output | 2 | Duty and bias code |
| frame_div_o | output | 2 | Frame rate divider select |
| latch_mode_o | output | 1 | Latch after data input mode |
| addr_hold_o | output | 1 | Hold address after data byte |
| wr_mode_o | output | 2 | Write mode code |
| test_mode_o | output | 2 | Master, slave or test selection |
| int_bias_o | output | 1 | Internal drive supply select |
| addr_rst_o | output | 1 | Clear address at strobe rise after data |
| latch_flag_o | output | 1 | Latch on every strobe rise |
| disp_on_o | output | 1 | Display enable flag |
| wr_addr_o | output | 5 | Current RAM write group address |
| stb_rise_o | output | 1 | Synchronized strobe rise pulse |
| stb_fall_o | output | 1 | Synchronized strobe fall pulse |

## Verification
A shifter that has slipped by one or more bits shows up at the end of the next window. A command then decodes into the wrong class or field, or a data byte lands in the RAM rotated. A wrong write address is seen as soon as the window closes, through wr_addr_o and through a RAM read at the expected location. A broken wrap or hold shows up as a byte at the wrong location. A retained partial byte mis-decodes the very next command, so a flag is already wrong when the following strobe rise arrives.

// File: rtl/lcd_ser_pkg.sv
package lcd_ser_pkg;
  localparam int BYTE_W = 8;

  localparam logic [1:0] CLS_DISP   = 2'b00;
  localparam logic [1:0] CLS_DATA   = 2'b01;
  localparam logic [1:0] CLS_STATUS = 2'b10;
  localparam logic [1:0] CLS_ADDR   = 2'b11;

  // last valid group address per duty code
  function automatic logic [4:0] last_group(input logic [1:0] duty);
    case (duty)
      2'b10:   last_group = 5'd19;
      2'b11:   last_group = 5'd29;
      default: last_group = 5'd14;
    endcase
  endfunction
endpackage

// File: rtl/lcd_ser_sync.sv
module lcd_ser_sync #(
  parameter int         W       = 3,
  parameter int         STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/lcd_ser_shift.sv
module lcd_ser_shift #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         stb_s_i,
  input  logic         sclk_s_i,
  input  logic         sdat_s_i,
  output logic         stb_rise_o,
  output logic         stb_fall_o,
  output logic         byte_vld_o,
  output logic         is_cmd_o,
  output logic [W-1:0] byte_o
);
  localparam int CW = $clog2(W);
  localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

  logic          stb_q, sclk_q, first_q, vld_q, cmd_q;
  logic [CW-1:0] cnt_q;
  logic [W-1:0]  sh_q;
  logic          shift_en;

  assign stb_rise_o = stb_s_i & ~stb_q;
  assign stb_fall_o = ~stb_s_i & stb_q;
  assign shift_en   = ~stb_s_i & sclk_s_i & ~sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stb_q   <= 1'b1;
      sclk_q  <= 1'b0;
      first_q <= 1'b0;
      vld_q   <= 1'b0;
      cmd_q   <= 1'b0;
      cnt_q   <= '0;
      sh_q    <= '0;
    end else begin
      stb_q  <= stb_s_i;
      sclk_q <= sclk_s_i;
      vld_q  <= 1'b0;
      if (stb_s_i) begin
        cnt_q <= '0;  // drop partial byte
      end else if (shift_en) begin
        sh_q <= {sh_q[W-2:0], sdat_s_i};
        if (cnt_q == CNT_LAST) begin
          cnt_q   <= '0;
          vld_q   <= 1'b1;
          cmd_q   <= first_q;
          first_q <= 1'b0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (stb_fall_o) first_q <= 1'b1;
    end
  end

  assign byte_vld_o = vld_q;
  assign is_cmd_o   = cmd_q;
  assign byte_o     = sh_q;
endmodule

// File: rtl/lcd_ser_ctrl.sv
module lcd_ser_ctrl
  import lcd_ser_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              byte_vld_i,
  input  logic              is_cmd_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  logic              stb_rise_i,
  output logic [1:0]        duty_o,
  output logic [1:0]        frame_div_o,
  output logic              latch_mode_o,
  output logic              addr_hold_o,
  output logic [1:0]        wr_mode_o,
  output logic [1:0]        test_mode_o,
  output logic              int_bias_o,
  output logic              addr_rst_o,
  output logic              latch_flag_o,
  output logic              disp_on_o,
  output logic              wr_en_o,
  output logic [AW-1:0]     wr_addr_o
);
  logic [AW-1:0] addr_q, last_addr;
  logic          wrote_q;

  assign wr_en_o   = byte_vld_i & ~is_cmd_i;
  assign last_addr = AW'(last_group(duty_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_o       <= '0;
      frame_div_o  <= '0;
      latch_mode_o <= 1'b0;
      addr_hold_o  <= 1'b0;
      wr_mode_o    <= '0;
      test_mode_o  <= '0;
      int_bias_o   <= 1'b0;
      addr_rst_o   <= 1'b0;
      latch_flag_o <= 1'b0;
      disp_on_o    <= 1'b0;
      addr_q       <= '0;
      wrote_q      <= 1'b0;
    end else begin
      if (byte_vld_i && is_cmd_i) begin
        unique case (byte_i[7:6])
          CLS_DISP: begin
            duty_o      <= byte_i[1:0];
            frame_div_o <= byte_i[3:2];
          end
          CLS_DATA: begin
            if (!byte_i[1]) begin  // 1x write modes rejected
              latch_mode_o <= byte_i[3];
              addr_hold_o  <= byte_i[2];
              wr_mode_o    <= byte_i[1:0];
            end
          end
          CLS_STATUS: begin
            test_mode_o  <= byte_i[5:4];
            int_bias_o   <= byte_i[3];
            addr_rst_o   <= byte_i[2];
            latch_flag_o <= byte_i[1];
            disp_on_o    <= byte_i[0];
          end
          CLS_ADDR: begin
            if (!byte_i[5]) addr_q <= AW'(byte_i[4:0]);
          end
        endcase
      end else if (wr_en_o) begin
        wrote_q <= 1'b1;
        if (!addr_hold_o) addr_q <= (addr_q >= last_addr) ? '0 : addr_q + 1'b1;
      end
      if (stb_rise_i) begin
        wrote_q <= 1'b0;
        if (addr_rst_o && (wrote_q || wr_en_o)) addr_q <= '0;
      end
    end
  end

  assign wr_addr_o = addr_q;
endmodule

// File: rtl/lcd_ser_ram.sv
module lcd_ser_ram #(
  parameter int DEPTH = 30,
  parameter int W     = 8,
  parameter int AW    = 5
) (
  input  logic          clk_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [W-1:0]  rd_data_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (wr_en_i && wr_addr_i <= LAST) mem[wr_addr_i] <= wr_data_i;
  end

  assign rd_data_o = (rd_addr_i <= LAST) ? mem[rd_addr_i] : '0;
endmodule

// File: rtl/lcd_ser_if.sv
module lcd_ser_if
  import lcd_ser_pkg::*;
#(
  parameter int AW          = 5,
  parameter int DEPTH       = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              sclk_i,
  input  logic              sdata_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  output logic [1:0]        duty_o,
  output logic [1:0]        frame_div_o,
  output logic              latch_mode_o,
  output logic              addr_hold_o,
  output logic [1:0]        wr_mode_o,
  output logic [1:0]        test_mode_o,
  output logic              int_bias_o,
  output logic              addr_rst_o,
  output logic              latch_flag_o,
  output logic              disp_on_o,
  output logic [AW-1:0]     wr_addr_o,
  output logic              stb_rise_o,
  output logic              stb_fall_o
);
  logic [2:0]        pins_s;
  logic              byte_vld, is_cmd, wr_en;
  logic [BYTE_W-1:0] rx_byte;

  lcd_ser_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    ({stb_i, sclk_i, sdata_i}),
    .q_o    (pins_s)
  );

  lcd_ser_shift #(.W(BYTE_W)) u_shift (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stb_s_i    (pins_s[2]),
    .sclk_s_i   (pins_s[1]),
    .sdat_s_i   (pins_s[0]),
    .stb_rise_o (stb_rise_o),
    .stb_fall_o (stb_fall_o),
    .byte_vld_o (byte_vld),
    .is_cmd_o   (is_cmd),
    .byte_o     (rx_byte)
  );

  lcd_ser_ctrl #(.AW(AW)) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .byte_vld_i   (byte_vld),
    .is_cmd_i     (is_cmd),
    .byte_i       (rx_byte),
    .stb_rise_i   (stb_rise_o),
    .duty_o       (duty_o),
    .frame_div_o  (frame_div_o),
    .latch_mode_o (latch_mode_o),
    .addr_hold_o  (addr_hold_o),
    .wr_mode_o    (wr_mode_o),
    .test_mode_o  (test_mode_o),
    .int_bias_o   (int_bias_o),
    .addr_rst_o   (addr_rst_o),
    .latch_flag_o (latch_flag_o),
    .disp_on_o    (disp_on_o),
    .wr_en_o      (wr_en),
    .wr_addr_o    (wr_addr_o)
  );

  lcd_ser_ram #(.DEPTH(DEPTH), .W(BYTE_W), .AW(AW)) u_ram (
    .clk_i     (clk_i),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr_o),
    .wr_data_i (rx_byte),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o)
  );
endmodule

// File: rtl/lcd_ser_if_chk.sv
module lcd_ser_if_chk
  import lcd_ser_pkg::*;
#(
  parameter int AW = 5
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              byte_vld,
  input logic              is_cmd,
  input logic [BYTE_W-1:0] rx_byte,
  input logic              stb_rise_o,
  input logic              stb_fall_o,
  input logic [AW-1:0]     wr_addr_o,
  input logic [1:0]        duty_o,
  input logic              addr_hold_o,
  input logic              latch_mode_o,
  input logic [1:0]        wr_mode_o
);
  logic data_wr;
  assign data_wr = byte_vld & ~is_cmd & ~stb_rise_o;

  p_edge_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(stb_rise_o && stb_fall_o));

  p_rise_single_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_rise_o |=> !stb_rise_o);

  p_hold_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && addr_hold_o |=> $stable(wr_addr_o));

  p_incr_addr_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && !addr_hold_o && wr_addr_o < AW'(last_group(duty_o))
    |=> wr_addr_o == $past(wr_addr_o) + 1'b1);

  p_wrap_addr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_wr && !addr_hold_o && wr_addr_o == AW'(last_group(duty_o))
    |=> wr_addr_o == '0);

  p_bad_wmode_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld && is_cmd && rx_byte[7:6] == 2'b01 && rx_byte[1]
    |=> $stable({latch_mode_o, addr_hold_o, wr_mode_o}));

  p_wmode_legal_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_mode_o[1]);
endmodule

bind lcd_ser_if lcd_ser_if_chk #(.AW(AW)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .byte_vld     (byte_vld),
  .is_cmd       (is_cmd),
  .rx_byte      (rx_byte),
  .stb_rise_o   (stb_rise_o),
  .stb_fall_o   (stb_fall_o),
  .wr_addr_o    (wr_addr_o),
  .duty_o       (duty_o),
  .addr_hold_o  (addr_hold_o),
  .latch_mode_o (latch_mode_o),
  .wr_mode_o    (wr_mode_o)
);

// File: tb/lcd_ser_if_tb_top.sv
module lcd_ser_if_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       stb = 1'b1, sclk = 1'b0, sdat = 1'b0;
  logic [4:0] rd_addr = '0;
  logic [7:0] rd_data;
  logic [1:0] duty, frame_div, wr_mode, test_mode;
  logic       latch_mode, addr_hold, int_bias, addr_rst, latch_flag, disp_on;
  logic [4:0] wr_addr;
  logic       stb_rise, stb_fall;

  int checks = 0, failures = 0;
  int rise_cnt = 0, fall_cnt = 0, frames = 0;

  always #4 clk = ~clk;

  lcd_ser_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .sclk_i(sclk), .sdata_i(sdat),
    .rd_addr_i(rd_addr), .rd_data_o(rd_data), .duty_o(duty),
    .frame_div_o(frame_div), .latch_mode_o(latch_mode), .addr_hold_o(addr_hold),
    .wr_mode_o(wr_mode), .test_mode_o(test_mode), .int_bias_o(int_bias),
    .addr_rst_o(addr_rst), .latch_flag_o(latch_flag), .disp_on_o(disp_on),
    .wr_addr_o(wr_addr), .stb_rise_o(stb_rise), .stb_fall_o(stb_fall)
  );

  always @(posedge clk) begin
    if (rst_n && stb_rise) rise_cnt++;
    if (rst_n && stb_fall) fall_cnt++;
  end

  typedef struct packed {
    logic [7:0] cmd;
    logic [1:0] duty, frame;
    logic       lm, hold;
    logic [1:0] wm, test;
    logic       ib, ar, lf, on;
  } vec_t;

  // R3 R4 R5 R6: one command per window, flags expected afterwards
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{8'h0E, 2'd2, 2'd3, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h33, 2'd3, 2'd0, 1'b0, 1'b0, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h4C, 2'd3, 2'd0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h4A, 2'd3, 2'd0, 1'b1, 1'b1, 2'd0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h41, 2'd3, 2'd0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'hBF, 2'd3, 2'd0, 1'b0, 1'b0, 2'd1, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1},
    '{8'h95, 2'd3, 2'd0, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{8'hE5, 2'd3, 2'd0, 1'b0, 1'b0, 2'd1, 2'd1, 1'b0, 1'b1, 1'b0, 1'b1},
    '{8'h80, 2'd3, 2'd0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0},
    '{8'h01, 2'd1, 2'd0, 1'b0, 1'b0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0}
  };

  function automatic logic [13:0] flags_now();
    return {duty, frame_div, latch_mode, addr_hold, wr_mode, test_mode,
            int_bias, addr_rst, latch_flag, disp_on};
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bits(input int n, input logic [7:0] v);
    for (int i = 7; i > 7 - n; i--) begin
      sdat = v[i];
      wait_clk(3);
      sclk = 1'b1;
      wait_clk(3);
      sclk = 1'b0;
    end
    wait_clk(3);
  endtask

  task automatic open_win();
    stb = 1'b0;
    frames++;
    wait_clk(4);
  endtask

  task automatic close_win();
    stb = 1'b1;
    wait_clk(6);
  endtask

  task automatic cmd_frame(input logic [7:0] c);
    open_win();
    send_bits(8, c);
    close_win();
  endtask

  task automatic data_frame(input logic [7:0] c, input logic [7:0] d0,
                            input logic [7:0] d1, input int nd);
    open_win();
    send_bits(8, c);
    if (nd > 0) send_bits(8, d0);
    if (nd > 1) send_bits(8, d1);
    close_win();
  endtask

  task automatic ram_chk(input logic [4:0] a, input logic [7:0] exp, input string req);
    rd_addr = a;
    #1;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(3);
    // R1
    chk(flags_now() == 14'd0, "R1 flags", flags_now(), 0);
    chk(wr_addr == 5'd0, "R1 addr", wr_addr, 0);

    for (int v = 0; v < NV; v++) begin
      cmd_frame(VECS[v].cmd);
      chk(flags_now() == VECS[v][13:0], "R3/R4/R5/R6 table", flags_now(), VECS[v][13:0]);
    end

    // R7 R8 R9: 1/2 duty wraps after 14
    cmd_frame(8'h00);
    data_frame(8'hCD, 8'hA0, 8'hA1, 2);
    open_win(); send_bits(8, 8'hC0 | 8'h0E); close_win(); // reload 14 for third byte path
    data_frame(8'hCE, 8'hA1, 8'hA2, 2);
    chk(wr_addr == 5'd1, "R9 wrap duty0", wr_addr, 1);
    ram_chk(5'd13, 8'hA0, "R7/R8 byte at 13");
    ram_chk(5'd14, 8'hA1, "R8 byte at 14");
    ram_chk(5'd0, 8'hA2, "R9 byte at 0 after wrap");

    // R9: 1/3 duty wraps after 19
    cmd_frame(8'h02);
    data_frame(8'hD3, 8'hB0, 8'hB1, 2);
    chk(wr_addr == 5'd1, "R9 wrap duty2", wr_addr, 1);
    ram_chk(5'd19, 8'hB0, "R9 byte at 19");
    ram_chk(5'd0, 8'hB1, "R9 byte at 0 duty2");

    // R9: 1/4 duty goes on past 19 and wraps after 29
    cmd_frame(8'h03);
    data_frame(8'hD3, 8'hD0, 8'h00, 1);
    chk(wr_addr == 5'd20, "R9 no wrap at 19 duty3", wr_addr, 20);
    data_frame(8'hDD, 8'hC0, 8'hC1, 2);
    chk(wr_addr == 5'd1, "R9 wrap duty3", wr_addr, 1);
    ram_chk(5'd29, 8'hC0, "R9 byte at 29");
    ram_chk(5'd0, 8'hC1, "R9 byte at 0 duty3");

    // R8: hold mode keeps the address
    cmd_frame(8'h45);
    data_frame(8'hC5, 8'h11, 8'h22, 2);
    chk(wr_addr == 5'd5, "R8 hold addr", wr_addr, 5);
    ram_chk(5'd5, 8'h22, "R8 hold overwrite");
    cmd_frame(8'h41);

    // R2: clocks with strobe high are ignored
    ram_chk(5'd6, 8'h00, "R2 pre");
    begin
      logic [4:0] a0;
      logic [7:0] m0;
      cmd_frame(8'hC6);
      a0 = wr_addr;
      rd_addr = 5'd6; #1; m0 = rd_data;
      send_bits(8, 8'hFF);
      send_bits(8, 8'h5A);
      chk(wr_addr == a0, "R2 addr unchanged", wr_addr, a0);
      ram_chk(5'd6, m0, "R2 ram unchanged");
    end

    // R10: address reset on strobe rise only after data
    cmd_frame(8'h84);
    data_frame(8'hC7, 8'h33, 8'h00, 1);
    chk(wr_addr == 5'd0, "R10 cleared after data", wr_addr, 0);
    ram_chk(5'd7, 8'h33, "R10 data stored");
    cmd_frame(8'hC9);
    chk(wr_addr == 5'd9, "R10 kept without data", wr_addr, 9);
    cmd_frame(8'h80);

    // R11: partial byte dropped
    cmd_frame(8'h02);
    open_win(); send_bits(4, 8'h30); close_win();
    chk(duty == 2'd2, "R11 partial no effect", duty, 2);
    cmd_frame(8'h01);
    chk(duty == 2'd1, "R11 fresh command", duty, 1);

    // R12
    chk(rise_cnt == frames, "R12 rise pulses", rise_cnt, frames);
    chk(fall_cnt == frames, "R12 fall pulses", fall_cnt, frames);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule